// File: doc/BRIEF.md
# Byte-Serial Descriptor CRC-32 Engine

This block computes a 32-bit cyclic redundancy check over a stream of bytes, one byte per clock, for protecting command descriptors. The divisor is x^32 + x^29 + x^18 + x^14 + x^3 + 1 (normal form 0x20044009). Bits are consumed most significant first. No bit reflection is applied on the input or the output, and the result is not inverted. A general-purpose Ethernet CRC-32 core therefore produces different values and cannot stand in for this engine.

Bytes arrive as beats on a valid/ready input. Each beat carries a byte, a first-beat marker, a final-beat marker and a keep flag that says whether the byte counts. A first beat loads the running value from the seed input. That seed is 0xFFFFFFFF for a fresh message, or any earlier result when a computation is resumed. A final beat publishes the result one cycle later together with a single-cycle done pulse. A beat with keep low carries no byte, so a first+final beat with keep low describes an empty message. The byte-update network is chosen by a parameter: a 256-entry table computed at elaboration, or an unrolled eight-step XOR network.

Top module: `crc32_byte_stream`

## Requirements
- R1: Each accepted kept byte d updates the running value c MSB-first. Eight times in turn, a feedback bit is taken as c[31] XOR the next bit of d (bit 7 first); c is shifted left by one; and 0x20044009 is XORed in when the feedback bit is 1. No reflection and no final XOR are applied.
- R2: The bytes 0x01, 0x02, 0x03, 0x04 with seed 0xFFFFFFFF give the result 0xF33CB7D3.
- R3: A beat with beat_first_i high loads seed_i before applying its byte, whatever the seed value. Resuming with an earlier result as the seed gives the same value as one unbroken message.
- R4: A beat with beat_first_i low continues from the running value left by the previous accepted beat.
- R5: crc_o and crc_done_o update on the clock edge that accepts a final beat. crc_done_o is high for exactly that one cycle unless another final beat is accepted.
- R6: A cycle with beat_valid_i low changes neither the running value nor the outputs, whatever the other inputs carry.
- R7: crc_o holds its value in every cycle in which crc_done_o is low.
- R8: A beat with beat_first_i, beat_final_i high and beat_keep_i low (an empty message) returns seed_i unchanged as the result.
- R9: An accepted beat with beat_keep_i low leaves the running value unchanged.
- R10: After reset, crc_o is 0, crc_done_o is 0, and beat_ready_o is high from the first clock after reset is released.
- R11: The table variant and the unrolled XOR variant give identical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_i | input | 32 | Starting value loaded on a first beat |
| beat_valid_i | input | 1 | Beat present |
| beat_ready_o | output | 1 | Engine accepts beats |
| beat_first_i | input | 1 | Beat starts a message |
| beat_final_i | input | 1 | Beat ends a message |
| beat_keep_i | input | 1 | Byte of this beat is counted |
| beat_byte_i | input | 8 | Data byte |
| crc_o | output | 32 | Result of the last completed message |
| crc_done_o | output | 1 | One-cycle pulse when crc_o is updated |

## Verification
The bench checks the published vector. A reflected or inverted implementation misses it at once. It also checks messages of several lengths and seeds against a bit-serial model. Messages split across two runs confirm that seeding from a prior result works, where a design that ignored the seed would restart from all ones. Idle gaps with garbage on the data and marker lines are inserted mid-message, as are keep-low beats and an empty message. A design that sampled without valid or applied dropped bytes would corrupt the value, and one mishandling the empty case would return a shifted seed. The result is watched across idle cycles and a following first beat, to catch a design that leaks the running value to crc_o or stretches the done pulse.

// File: rtl/crcb_pkg.sv
package crcb_pkg;
   typedef enum logic {
      STEP_TABLE = 1'b0,
      STEP_XOR   = 1'b1
   } step_kind_e;

   localparam int unsigned CRCB_W_DEF    = 32;
   localparam int unsigned CRCB_BYTE_DEF = 8;
endpackage

// File: rtl/crcb_byte_step.sv
module crcb_byte_step
   import crcb_pkg::*;
#(
   parameter int unsigned CRC_W  = 32,
   parameter int unsigned BYTE_W = 8,
   parameter logic [CRC_W-1:0] POLY = 32'h20044009,
   parameter step_kind_e KIND = STEP_TABLE
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [CRC_W-1:0]  crc_out
);
   localparam int unsigned PAD_W   = CRC_W - BYTE_W;
   localparam int unsigned TBL_DEP = 1 << BYTE_W;

   if (CRC_W <= BYTE_W) begin : g_bad_width
      $error("crcb_byte_step: CRC_W must exceed BYTE_W");
   end
   if (BYTE_W > 8) begin : g_bad_byte
      $error("crcb_byte_step: BYTE_W above 8 makes the table too large");
   end

   // Shift a value left BYTE_W times, folding in POLY on each carry out.
   function automatic logic [CRC_W-1:0] fold(input logic [CRC_W-1:0] v);
      logic [CRC_W-1:0] c;
      c = v;
      for (int k = 0; k < int'(BYTE_W); k++) begin
         if (c[CRC_W-1]) c = {c[CRC_W-2:0], 1'b0} ^ POLY;
         else            c = {c[CRC_W-2:0], 1'b0};
      end
      return c;
   endfunction

   if (KIND == STEP_TABLE) begin : g_table
      logic [CRC_W-1:0]  tbl [TBL_DEP];
      logic [BYTE_W-1:0] idx;
      for (genvar i = 0; i < int'(TBL_DEP); i++) begin : g_ent
         assign tbl[i] = fold({BYTE_W'(i), {PAD_W{1'b0}}});
      end
      assign idx     = crc_in[CRC_W-1 -: BYTE_W] ^ byte_in;
      assign crc_out = {crc_in[PAD_W-1:0], {BYTE_W{1'b0}}} ^ tbl[idx];
   end else begin : g_xor
      assign crc_out = fold(crc_in ^ {byte_in, {PAD_W{1'b0}}});
   end
endmodule

// File: rtl/crcb_accum.sv
module crcb_accum #(
   parameter int unsigned CRC_W = 32,
   parameter logic [CRC_W-1:0] SEED_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             first,
   input  logic             final_b,
   input  logic             keep,
   input  logic [CRC_W-1:0] seed,
   input  logic [CRC_W-1:0] stepped,
   output logic [CRC_W-1:0] base,
   output logic [CRC_W-1:0] result,
   output logic             done
);
   logic [CRC_W-1:0] run_q;
   logic [CRC_W-1:0] next_val;

   assign base     = first ? seed : run_q;
   assign next_val = keep ? stepped : base;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= SEED_RST;
         result <= '0;
         done   <= 1'b0;
      end else begin
         done <= take & final_b;
         if (take) begin
            run_q <= next_val;
            if (final_b) result <= next_val;
         end
      end
   end

   // R5: a final beat produces done on the next cycle
   a_r5_done_after_final: assert property (@(posedge clk) disable iff (!rst_n)
      (take && final_b) |=> done);
   // R5: done never appears without a final beat
   a_r5_done_needs_final: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(take && final_b));
   // R6: idle cycles keep the running value
   a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(run_q));
   // R7: result only moves with done
   a_r7_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));
   // R8: empty message returns the seed
   a_r8_empty_seed: assert property (@(posedge clk) disable iff (!rst_n)
      (take && first && final_b && !keep) |=> (result == $past(seed)));
   // R9: a dropped byte leaves the running value
   a_r9_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !first && !keep) |=> $stable(run_q));
endmodule

// File: rtl/crc32_byte_stream.sv
module crc32_byte_stream
   import crcb_pkg::*;
#(
   parameter int unsigned CRC_W  = CRCB_W_DEF,
   parameter int unsigned BYTE_W = CRCB_BYTE_DEF,
   parameter logic [CRC_W-1:0] POLY = 32'h20044009,
   parameter logic [CRC_W-1:0] SEED_RST = '1,
   parameter step_kind_e KIND = STEP_TABLE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CRC_W-1:0]  seed_i,
   input  logic              beat_valid_i,
   output logic              beat_ready_o,
   input  logic              beat_first_i,
   input  logic              beat_final_i,
   input  logic              beat_keep_i,
   input  logic [BYTE_W-1:0] beat_byte_i,
   output logic [CRC_W-1:0]  crc_o,
   output logic              crc_done_o
);
   logic             ready_q;
   logic             take;
   logic [CRC_W-1:0] base;
   logic [CRC_W-1:0] stepped;

   always_ff @(posedge clk) begin
      if (!rst_n) ready_q <= 1'b0;
      else        ready_q <= 1'b1;
   end

   assign beat_ready_o = ready_q;
   assign take         = beat_valid_i & ready_q;

   crcb_byte_step #(
      .CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY(POLY), .KIND(KIND)
   ) u_step (
      .crc_in(base), .byte_in(beat_byte_i), .crc_out(stepped)
   );

   crcb_accum #(
      .CRC_W(CRC_W), .SEED_RST(SEED_RST)
   ) u_acc (
      .clk(clk), .rst_n(rst_n), .take(take), .first(beat_first_i),
      .final_b(beat_final_i), .keep(beat_keep_i), .seed(seed_i),
      .stepped(stepped), .base(base), .result(crc_o), .done(crc_done_o)
   );

   // R10: ready comes up the cycle after reset is released
   a_r10_ready_up: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> beat_ready_o);
endmodule

// File: tb/sim_crc32_byte_stream.sv
`timescale 1ns/1ps
module sim_crc32_byte_stream;
   import crcb_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] seed_i = 32'hFFFF_FFFF;
   logic        beat_valid_i = 1'b0;
   logic        beat_first_i = 1'b0;
   logic        beat_final_i = 1'b0;
   logic        beat_keep_i = 1'b0;
   logic [7:0]  beat_byte_i = 8'h00;
   logic        rdy0, rdy1, done0, done1;
   logic [31:0] crc0, crc1;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2 clk = ~clk;

   crc32_byte_stream #(.KIND(STEP_TABLE)) u0 (
      .clk(clk), .rst_n(rst_n), .seed_i(seed_i), .beat_valid_i(beat_valid_i),
      .beat_ready_o(rdy0), .beat_first_i(beat_first_i), .beat_final_i(beat_final_i),
      .beat_keep_i(beat_keep_i), .beat_byte_i(beat_byte_i), .crc_o(crc0), .crc_done_o(done0));

   crc32_byte_stream #(.KIND(STEP_XOR)) u1 (
      .clk(clk), .rst_n(rst_n), .seed_i(seed_i), .beat_valid_i(beat_valid_i),
      .beat_ready_o(rdy1), .beat_first_i(beat_first_i), .beat_final_i(beat_final_i),
      .beat_keep_i(beat_keep_i), .beat_byte_i(beat_byte_i), .crc_o(crc1), .crc_done_o(done1));

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=<100000", cyc);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   function automatic logic [31:0] m_byte(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] v;
      v = c;
      for (int b = 7; b >= 0; b--) begin
         logic fb;
         fb = v[31] ^ d[b];
         v  = {v[30:0], 1'b0};
         if (fb) v = v ^ 32'h20044009;
      end
      return v;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic beat(input logic [7:0] d, input logic f, input logic l, input logic k);
      beat_byte_i  = d;
      beat_first_i = f;
      beat_final_i = l;
      beat_keep_i  = k;
      beat_valid_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      beat_valid_i = 1'b0;
   endtask

   // idle cycles with garbage on every line except valid
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         beat_byte_i  = 8'(8'hA5 ^ i);
         beat_first_i = 1'b1;
         beat_final_i = 1'b1;
         beat_keep_i  = 1'b1;
         @(posedge clk);
         @(negedge clk);
      end
      beat_first_i = 1'b0;
      beat_final_i = 1'b0;
   endtask

   // called right after a final beat: result now, pulse gone one cycle later
   task automatic check_result(input string tag, input logic [31:0] exp);
      chk(tag, crc0, exp);
      chk({tag, " R5 done"}, {31'b0, done0}, 32'd1);
      chk({tag, " R11 xor variant"}, crc1, exp);
      @(posedge clk);
      @(negedge clk);
      chk({tag, " R5 done pulse width"}, {31'b0, done0}, 32'd0);
   endtask

   task automatic send_msg(input logic [31:0] s, input int n, input logic [7:0] m [16],
                           output logic [31:0] exp);
      exp    = s;
      seed_i = s;
      for (int i = 0; i < n; i++) begin
         exp = m_byte(exp, m[i]);
         beat(m[i], i == 0, i == n - 1, 1'b1);
      end
   endtask

   task automatic t_reset;
      chk("R10 reset crc", crc0, 32'h0);
      chk("R10 reset done", {31'b0, done0}, 32'd0);
      chk("R10 ready", {31'b0, rdy0}, 32'd1);
   endtask

   task automatic t_vector;
      seed_i = 32'hFFFF_FFFF;
      beat(8'h01, 1'b1, 1'b0, 1'b1);
      beat(8'h02, 1'b0, 1'b0, 1'b1);
      beat(8'h03, 1'b0, 1'b0, 1'b1);
      beat(8'h04, 1'b0, 1'b1, 1'b1);
      check_result("R2 R1 vector", 32'hF33C_B7D3);
   endtask

   task automatic t_patterns;
      logic [7:0]  m [16];
      logic [31:0] e;
      int          lens [3] = '{1, 7, 16};
      logic [31:0] seeds [3] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hDEAD_BEEF};
      for (int p = 0; p < 3; p++) begin
         for (int i = 0; i < 16; i++) m[i] = 8'((i * 37 + lens[p] * 11) ^ 8'h5A);
         send_msg(seeds[p], lens[p], m, e);
         check_result("R1 R4 pattern", e);
      end
   endtask

   task automatic t_split;
      logic [7:0]  m [16];
      logic [7:0]  m2 [16];
      logic [31:0] e1, e2, whole;
      for (int i = 0; i < 16; i++) m[i] = 8'(i * 13 + 7);
      whole = 32'hFFFF_FFFF;
      for (int i = 0; i < 10; i++) whole = m_byte(whole, m[i]);
      send_msg(32'hFFFF_FFFF, 4, m, e1);
      check_result("R3 split part one", e1);
      for (int i = 0; i < 16; i++) m2[i] = (i < 12) ? m[i + 4] : 8'h00;
      send_msg(crc0, 6, m2, e2);
      check_result("R3 resumed seed", whole);
   endtask

   task automatic t_gaps;
      seed_i = 32'hFFFF_FFFF;
      idle(2);
      beat(8'h01, 1'b1, 1'b0, 1'b1);
      idle(3);
      beat(8'h02, 1'b0, 1'b0, 1'b1);
      idle(1);
      beat(8'h03, 1'b0, 1'b0, 1'b1);
      seed_i = 32'h1234_5678;
      idle(4);
      beat(8'h04, 1'b0, 1'b1, 1'b1);
      check_result("R6 gaps", 32'hF33C_B7D3);
   endtask

   task automatic t_keep0;
      seed_i = 32'hFFFF_FFFF;
      beat(8'h01, 1'b1, 1'b0, 1'b1);
      beat(8'hAA, 1'b0, 1'b0, 1'b0);
      beat(8'h02, 1'b0, 1'b0, 1'b1);
      beat(8'h03, 1'b0, 1'b0, 1'b1);
      beat(8'h04, 1'b0, 1'b0, 1'b1);
      beat(8'h55, 1'b0, 1'b1, 1'b0);
      check_result("R9 dropped bytes", 32'hF33C_B7D3);
   endtask

   task automatic t_empty;
      seed_i = 32'h1357_9BDF;
      beat(8'hC3, 1'b1, 1'b1, 1'b0);
      check_result("R8 empty message", 32'h1357_9BDF);
   endtask

   task automatic t_hold;
      logic [31:0] held;
      held = crc0;
      idle(5);
      chk("R7 hold after idle", crc0, held);
      chk("R7 no done while idle", {31'b0, done0}, 32'd0);
      seed_i = 32'hFFFF_FFFF;
      beat(8'h01, 1'b1, 1'b0, 1'b1);
      chk("R7 hold after first beat", crc0, held);
      beat(8'h02, 1'b0, 1'b1, 1'b1);
      check_result("R4 close after hold", m_byte(m_byte(32'hFFFF_FFFF, 8'h01), 8'h02));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      t_reset();
      t_vector();
      t_patterns();
      t_split();
      t_gaps();
      t_keep0();
      t_empty();
      t_hold();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule